// File: doc/BRIEF.md
# Pointer Exchange Post-Modify Unit

This unit swaps one 16-bit half of a 32-bit accumulator-side register `y` with a word of data memory. The memory address comes from one of several pointer registers. A command carries a selector field `cmd_z` and a half-select bit `cmd_x`. The upper bits of `cmd_z` pick the pointer, and its two low bits pick how that pointer moves. The pointer moves twice during one exchange. The first move happens between the memory read and the memory write. The second move happens after the write, and it uses a different table of meanings for the same two bits.

Once a command is accepted, the unit spends two busy cycles. In the first it reads memory at the pointer. In the second it writes the old `y` half to the pointer as modified by the first move. The half of `y` that was read is refreshed at the end of the second cycle, and the pointer takes its final value at the same moment. A one-cycle `done` pulse follows.

A host-side port loads pointers, the `j` and `k` step registers, and `y`. The same values are visible on output buses. The command input follows valid/ready rules. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the two busy cycles, so a command offered then stays pending and has no effect. The memory side has no back-pressure: read data is expected exactly one cycle after `mem_re`.

Top module: `ptr_xchg_unit`

## Requirements
- R1: After reset, all pointers, `j`, `k` and `y` read 0, `cmd_ready` is 1, and `done`, `mem_re` and `mem_we` are 0.
- R2: A command is accepted on an edge with `cmd_valid` and `cmd_ready` both high. In the next cycle `mem_re` is 1, `mem_we` is 0, `cmd_ready` is 0, and `mem_addr` equals the pointer whose index is `cmd_z[3:2]`.
- R3: In the second busy cycle `mem_addr` is the pointer after the first move. The first move is chosen by `cmd_z[1:0]`: 00 keeps it, 01 adds 1, 10 subtracts 1, 11 adds `j`.
- R4: The second busy cycle follows the read cycle directly. In it `mem_we` is 1, `mem_re` is 0, and `mem_wdata` is the old `y[15:0]` when `cmd_x`=0 or the old `y[31:16]` when `cmd_x`=1.
- R5: At the end of the second busy cycle, the selected half of `y` takes the value returned on `mem_rdata` for the read. The other half keeps its value.
- R6: The selected pointer finally holds its value after the first move, then a second move chosen by `cmd_z[1:0]`: 00 adds 1, 01 keeps it, 10 adds 2, 11 adds `k`.
- R7: An exchange leaves unchanged every pointer it does not select, as well as `j` and `k`.
- R8: `done` is high for exactly the one cycle after the write cycle, with `cmd_ready` already high. A command offered in that cycle is accepted and uses the updated pointer.
- R9: While busy, a pending command, host register writes (`cfg_we`) and `y` loads (`y_we`) have no effect.
- R10: Pointer arithmetic wraps modulo 2^16, and `j` and `k` act as two's-complement steps.
- R11: When idle, `cfg_we` writes `cfg_wdata` to pointer `cfg_sel` for `cfg_sel` in 0..3, to `j` for 4, and to `k` for 5. `y_we` loads `y_wdata`. The new values appear on the output buses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| cmd_z | input | 4 | Pointer index [3:2] and move code [1:0] |
| cmd_x | input | 1 | 0: exchange y[15:0], 1: exchange y[31:16] |
| done | output | 1 | One-cycle completion pulse |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 3 | 0-3 pointer, 4 j, 5 k |
| cfg_wdata | input | 16 | Host write data |
| y_we | input | 1 | Load y |
| y_wdata | input | 32 | y load value |
| y_q | output | 32 | Current y |
| ptr_q | output | 64 | All pointers, pointer n at bits [16n+15:16n] |
| j_q | output | 16 | Current j |
| k_q | output | 16 | Current k |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_re |

## Verification
The `done` cycle of one exchange is also the idle cycle in which the next command can be taken. That next command must address memory with the pointer the previous exchange has just finalized. The bench provokes this overlap by chaining random commands with no gap, often on the same pointer. It judges the overlap by checking that `done` and `cmd_ready` rise together and that the next read address matches the model's post-modified pointer. Host writes and pending commands are also thrown at the unit during its busy cycles, where they coincide with the sequencer's own pointer updates. The final register values must show that only the sequencer acted.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    PX_IDLE = 2'd0,
    PX_RD   = 2'd1,
    PX_WR   = 2'd2
  } px_state_t;

  // host register selector values beyond the pointer indices
  function automatic int unsigned sel_j(input int unsigned nptr);
    return nptr;
  endfunction
  function automatic int unsigned sel_k(input int unsigned nptr);
    return nptr + 1;
  endfunction
endpackage

// File: rtl/pxu_regfile.sv
module pxu_regfile #(
  parameter int DW    = 16,
  parameter int NPTR  = 4,
  parameter int PSW   = $clog2(NPTR),
  parameter int CSELW = $clog2(NPTR + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [CSELW-1:0] host_sel,
  input  logic [DW-1:0]    host_data,
  input  logic             upd_en,
  input  logic [PSW-1:0]   upd_idx,
  input  logic [DW-1:0]    upd_val,
  output logic [NPTR*DW-1:0] ptr_flat,
  output logic [DW-1:0]    j_out,
  output logic [DW-1:0]    k_out
);
  import pxu_pkg::*;

  localparam int unsigned JSEL = sel_j(NPTR);
  localparam int unsigned KSEL = sel_k(NPTR);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r <= '0;
      else if (upd_en && (upd_idx == PSW'(g)))
        r <= upd_val;
      else if (host_we && (host_sel == CSELW'(g)))
        r <= host_data;
    end
    assign ptr_flat[g*DW +: DW] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_out <= '0;
      k_out <= '0;
    end else if (host_we) begin
      if (host_sel == CSELW'(JSEL)) j_out <= host_data;
      if (host_sel == CSELW'(KSEL)) k_out <= host_data;
    end
  end
endmodule

// File: rtl/pxu_step.sv
module pxu_step #(
  parameter int DW    = 16,
  parameter int PHASE = 0
) (
  input  logic [DW-1:0] cur,
  input  logic [1:0]    code,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] nxt
);
  if (PHASE == 0) begin : g_first
    always_comb begin
      unique case (code)
        2'b00:   nxt = cur;
        2'b01:   nxt = cur + DW'(1);
        2'b10:   nxt = cur - DW'(1);
        default: nxt = cur + step;
      endcase
    end
  end else begin : g_second
    always_comb begin
      unique case (code)
        2'b00:   nxt = cur + DW'(1);
        2'b01:   nxt = cur;
        2'b10:   nxt = cur + DW'(2);
        default: nxt = cur + step;
      endcase
    end
  end
endmodule

// File: rtl/pxu_seq.sv
module pxu_seq #(
  parameter int ZW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [ZW-1:0] cmd_z,
  input  logic          cmd_x,
  output logic          cmd_ready,
  output logic          in_rd,
  output logic          in_wr,
  output logic          done,
  output logic [ZW-1:0] z_q,
  output logic          x_q
);
  import pxu_pkg::*;

  px_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PX_IDLE;
      z_q  <= '0;
      x_q  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= (st == PX_WR);
      unique case (st)
        PX_IDLE: if (cmd_valid) begin
          st  <= PX_RD;
          z_q <= cmd_z;
          x_q <= cmd_x;
        end
        PX_RD:   st <= PX_WR;
        default: st <= PX_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == PX_IDLE);
  assign in_rd     = (st == PX_RD);
  assign in_wr     = (st == PX_WR);
endmodule

// File: rtl/ptr_xchg_unit.sv
module ptr_xchg_unit #(
  parameter int  DW    = 16,
  parameter int  NPTR  = 4,
  localparam int PSW   = $clog2(NPTR),
  localparam int ZW    = PSW + 2,
  localparam int CSELW = $clog2(NPTR + 2),
  localparam int YW    = 2 * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ZW-1:0]      cmd_z,
  input  logic               cmd_x,
  output logic               done,
  input  logic               cfg_we,
  input  logic [CSELW-1:0]   cfg_sel,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic               y_we,
  input  logic [YW-1:0]      y_wdata,
  output logic [YW-1:0]      y_q,
  output logic [NPTR*DW-1:0] ptr_q,
  output logic [DW-1:0]      j_q,
  output logic [DW-1:0]      k_q,
  output logic               mem_re,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata
);
  logic          in_rd, in_wr;
  logic [ZW-1:0] z_q;
  logic          x_q;
  logic [PSW-1:0] idx;
  logic [DW-1:0] cur_ptr, nxt_first, nxt_second, upd_val;
  logic          host_ok;

  pxu_seq #(.ZW(ZW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_z(cmd_z),
    .cmd_x(cmd_x), .cmd_ready(cmd_ready), .in_rd(in_rd), .in_wr(in_wr),
    .done(done), .z_q(z_q), .x_q(x_q)
  );

  assign idx     = z_q[ZW-1:2];
  assign cur_ptr = ptr_q[idx*DW +: DW];
  assign host_ok = cmd_ready;

  pxu_step #(.DW(DW), .PHASE(0)) u_step_a (
    .cur(cur_ptr), .code(z_q[1:0]), .step(j_q), .nxt(nxt_first)
  );
  pxu_step #(.DW(DW), .PHASE(1)) u_step_b (
    .cur(cur_ptr), .code(z_q[1:0]), .step(k_q), .nxt(nxt_second)
  );

  assign upd_val = in_rd ? nxt_first : nxt_second;

  pxu_regfile #(.DW(DW), .NPTR(NPTR), .PSW(PSW), .CSELW(CSELW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .host_we(cfg_we && host_ok), .host_sel(cfg_sel), .host_data(cfg_wdata),
    .upd_en(in_rd || in_wr), .upd_idx(idx), .upd_val(upd_val),
    .ptr_flat(ptr_q), .j_out(j_q), .k_out(k_q)
  );

  // y register: host load when idle, half refresh at the end of the write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      y_q <= '0;
    else if (in_wr) begin
      if (x_q) y_q[YW-1:DW] <= mem_rdata;
      else     y_q[DW-1:0]  <= mem_rdata;
    end else if (y_we && host_ok)
      y_q <= y_wdata;
  end

  assign mem_re    = in_rd;
  assign mem_we    = in_wr;
  assign mem_addr  = cur_ptr;
  assign mem_wdata = x_q ? y_q[YW-1:DW] : y_q[DW-1:0];
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk #(
  parameter int DW = 16,
  parameter int ZW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [ZW-1:0] cmd_z,
  input logic          cmd_x,
  input logic          done,
  input logic [2*DW-1:0] y_q,
  input logic [DW-1:0] j_q,
  input logic          mem_re,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata
);
  logic [1:0]    code_c;
  logic          half_c;
  logic [DW-1:0] rd_addr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_c    <= '0;
      half_c    <= 1'b0;
      rd_addr_c <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        code_c <= cmd_z[1:0];
        half_c <= cmd_x;
      end
      if (mem_re) rd_addr_c <= mem_addr;
    end
  end

  function automatic logic [DW-1:0] first_move(input logic [DW-1:0] p,
                                               input logic [1:0] c,
                                               input logic [DW-1:0] s);
    case (c)
      2'b00:   return p;
      2'b01:   return p + DW'(1);
      2'b10:   return p - DW'(1);
      default: return p + s;
    endcase
  endfunction

  // R2
  accept_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (mem_re && !mem_we && !cmd_ready));

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && !mem_re));

  // R4
  no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R3
  write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == first_move(rd_addr_c, code_c, j_q)));

  // R4
  write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == (half_c ? y_q[2*DW-1:DW] : y_q[DW-1:0])));

  // R5
  y_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !half_c) |=> (y_q[DW-1:0] == $past(mem_rdata)) && (y_q[2*DW-1:DW] == $past(y_q[2*DW-1:DW])));

  // R5
  y_refresh_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && half_c) |=> (y_q[2*DW-1:DW] == $past(mem_rdata)) && (y_q[DW-1:0] == $past(y_q[DW-1:0])));

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (done && cmd_ready));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ptr_xchg_unit pxu_chk #(.DW(DW), .ZW(ZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_z(cmd_z), .cmd_x(cmd_x), .done(done), .y_q(y_q), .j_q(j_q),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/ptr_xchg_unit_tb.sv
`timescale 1ns/1ps
module ptr_xchg_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_z = '0;
  logic        cmd_x = 1'b0;
  logic        done;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        y_we = 1'b0;
  logic [31:0] y_wdata = '0;
  logic [31:0] y_q;
  logic [63:0] ptr_q;
  logic [15:0] j_q, k_q;
  logic        mem_re, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_ptr [4];
  logic [15:0] m_j, m_k;
  logic [31:0] m_y;
  logic [15:0] mem [256];

  always #4 clk = ~clk;

  ptr_xchg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_z(cmd_z), .cmd_x(cmd_x), .done(done), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .y_we(y_we), .y_wdata(y_wdata),
    .y_q(y_q), .ptr_q(ptr_q), .j_q(j_q), .k_q(k_q), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory model: one-cycle read latency, 256 words aliased on the low address byte
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 16'h9e37) ^ 16'h5a5a;
    end else begin
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  function automatic logic [15:0] move_a(logic [15:0] p, logic [1:0] c, logic [15:0] s);
    if (c == 2'd0) return p;
    if (c == 2'd1) return p + 16'd1;
    if (c == 2'd2) return p + 16'hffff;
    return p + s;
  endfunction

  function automatic logic [15:0] move_b(logic [15:0] p, logic [1:0] c, logic [15:0] s);
    if (c == 2'd1) return p;
    if (c == 2'd0) return p + 16'd1;
    if (c == 2'd2) return p + 16'd2;
    return p + s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 4; i++) chk(tag, 32'(ptr_q[i*16 +: 16]), 32'(m_ptr[i]));
    chk(tag, 32'(j_q), 32'(m_j));
    chk(tag, 32'(k_q), 32'(m_k));
    chk(tag, y_q, m_y);
  endtask

  // entered and left at a negedge; R11
  task automatic host_write(logic [2:0] sel, logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 3'd4) m_ptr[sel[1:0]] = d;
    else if (sel == 3'd4) m_j = d;
    else if (sel == 3'd5) m_k = d;
  endtask

  task automatic y_load(logic [31:0] d);
    y_we = 1'b1; y_wdata = d;
    @(posedge clk); @(negedge clk);
    y_we = 1'b0;
    m_y = d;
  endtask

  // one exchange; entered at a negedge with the unit idle, left at the done-cycle negedge
  task automatic exchange(logic [3:0] z, logic x, bit disturb);
    logic [1:0]  pi = z[3:2];
    logic [15:0] p  = m_ptr[pi];
    logic [15:0] a1 = move_a(p, z[1:0], m_j);
    logic [15:0] a2 = move_b(a1, z[1:0], m_k);
    logic [15:0] rd = mem[p[7:0]];
    logic [15:0] old = x ? m_y[31:16] : m_y[15:0];
    cmd_valid = 1'b1; cmd_z = z; cmd_x = x;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 read enable", 32'(mem_re), 32'd1);
    chk("R2 no write in read cycle", 32'(mem_we), 32'd0);
    chk("R2 ready low", 32'(cmd_ready), 32'd0);
    chk("R2 read address", 32'(mem_addr), 32'(p));
    if (disturb) begin
      cmd_valid = 1'b1; cmd_z = 4'($urandom); cmd_x = 1'($urandom);
      cfg_we = 1'b1; cfg_sel = 3'($urandom_range(0, 5)); cfg_wdata = 16'($urandom);
      y_we = 1'b1; y_wdata = $urandom;
    end
    @(posedge clk); @(negedge clk);
    chk("R4 write enable", 32'(mem_we), 32'd1);
    chk("R4 no read in write cycle", 32'(mem_re), 32'd0);
    chk("R3 write address", 32'(mem_addr), 32'(a1));
    chk("R4 write data", 32'(mem_wdata), 32'(old));
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cfg_we = 1'b0; y_we = 1'b0;
    if (x) m_y[31:16] = rd; else m_y[15:0] = rd;
    m_ptr[pi] = a2;
    chk("R8 done pulse", 32'(done), 32'd1);
    chk("R8 ready with done", 32'(cmd_ready), 32'd1);
    chk("R9 no read after done", 32'(mem_re), 32'd0);
    chk("R5 y after exchange", y_q, m_y);
    chk("R6 final pointer", 32'(ptr_q[pi*16 +: 16]), 32'(a2));
    check_regs(disturb ? "R9 registers after busy writes" : "R7 untouched registers");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    m_j = '0; m_k = '0; m_y = '0;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_regs("R1 reset registers");
    chk("R1 ready", 32'(cmd_ready), 32'd1);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 mem strobes", {30'd0, mem_re, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    host_write(3'd0, 16'h0010);
    host_write(3'd1, 16'hffff);
    host_write(3'd2, 16'h0000);
    host_write(3'd3, 16'h00f0);
    host_write(3'd4, 16'hfffd);
    host_write(3'd5, 16'h0005);
    y_load(32'hcafe_1234);
    check_regs("R11 host loads");

    // directed: every move code on each phase, both halves
    for (int c = 0; c < 4; c++) exchange({2'd0, 2'(c)}, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) exchange({2'd3, 2'(c)}, 1'b1, 1'b0);
    // R10 wrap upward and downward
    exchange(4'b0100, 1'b0, 1'b0);   // ffff keeps, then +1 -> 0000
    exchange(4'b1010, 1'b1, 1'b0);   // 0000 -1 -> ffff, +2 -> 0001
    exchange(4'b1011, 1'b0, 1'b0);   // R10 negative j step
    // R9 busy writes and pending command ignored
    exchange(4'b0111, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 pending command dropped", 32'(mem_re), 32'd0);

    // random mix; zero gap exercises back-to-back acceptance (R8)
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) host_write(3'($urandom_range(0, 5)), 16'($urandom));
      else if (r == 1) y_load($urandom);
      else if (r == 2) @(negedge clk);
      exchange(4'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0));
    end
    @(negedge clk);
    check_regs("R7 final registers");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule